// File: doc/BRIEF.md
# Heartbeat Interrupt Generator

This block produces the periodic system heartbeat interrupt for a processor board. A counter runs without stopping on the CPU bus clock and divides it by a fixed ratio. Each time the counter completes a period, the block asserts an active-low fast-interrupt request line. With the default ratio of 2048 and a 2 MHz clock, the request recurs at 976.5625 Hz.

The request is a level, not a pulse. It stays asserted until the CPU reads the DIP switch input port. The address decoder turns that read into a one-cycle strobe, and the strobe clears the request as a side effect. The CPU needs no separate acknowledge register.

If further periods elapse while a request is still pending, they merge into that one request. If a clearing read lands on the same edge as a period boundary, the fresh interrupt takes priority.

Top module: `heartbeat_irq`

## Requirements
- R1: While reset is high, `firq_n` is 1 (no request) and the period counter is held at its start value.
- R2: `firq_n` first goes to 0 (request) exactly `DIV_RATIO` clock edges after reset is released. With the default of 2048, this gives 976.5625 Hz from a 2 MHz clock.
- R3: Once `firq_n` is 0, it stays at 0 across any number of further period boundaries as long as `sw_rd` stays low.
- R4: When `sw_rd` is high at a rising edge that is not a period boundary, `firq_n` is 1 after that edge.
- R5: Period boundaries that occur while a request is pending are not queued. After a clearing read, `firq_n` stays at 1 until the next period boundary.
- R6: The counter runs freely and reads do not affect it. Requests begin every `DIV_RATIO` edges after reset release. A read while no request is pending leaves `firq_n` at 1.
- R7: When `sw_rd` is high at the same edge as a period boundary, `firq_n` is 0 after that edge: the new request wins.
- R8: Asserting reset in the middle of operation drops a pending request and restarts the counter. The next request comes `DIV_RATIO` edges after the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU bus clock that drives the period counter |
| rst | input | 1 | Synchronous reset, active high |
| sw_rd | input | 1 | One-cycle strobe from a read of the DIP switch port; clears the request |
| firq_n | output | 1 | Fast-interrupt request, active low, registered |

## Verification
The bench builds the main instance with `DIV_RATIO` set to 16. At that ratio a single run can cover many period boundaries, the same-edge collision of a read and a boundary, and a reset during operation. A second instance is built with the default ratio of 2048, so the bench can confirm that the first request lands at exactly edge 2048 after reset release. Both instances share the same clock, reset and read strobe.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Action applied to the request register on a clock edge.
  typedef enum logic [1:0] {
    HB_HOLD  = 2'd0,
    HB_RAISE = 2'd1,
    HB_DROP  = 2'd2
  } hb_action_e;

  // Width of a counter that must reach n-1.
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/hb_prescaler.sv
module hb_prescaler #(
  parameter int DIV_RATIO = 2048
) (
  input  logic clk,
  input  logic rst,
  output logic tc
);
  localparam int CW = hb_pkg::cnt_width(DIV_RATIO);
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q;

  // Terminal count: the last state of the period.
  assign tc = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tc) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hb_irq_latch.sv
module hb_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);
  import hb_pkg::*;

  hb_action_e act;

  // A set beats a clear that arrives on the same edge.
  always_comb begin
    if (set_i) begin
      act = HB_RAISE;
    end else if (clr_i) begin
      act = HB_DROP;
    end else begin
      act = HB_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
    end else begin
      case (act)
        HB_RAISE: irq_n <= 1'b0;
        HB_DROP:  irq_n <= 1'b1;
        default:  irq_n <= irq_n;
      endcase
    end
  end
endmodule

// File: rtl/heartbeat_irq.sv
module heartbeat_irq #(
  parameter int DIV_RATIO = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_rd,
  output logic firq_n
);
  logic tc;

  hb_prescaler #(
    .DIV_RATIO(DIV_RATIO)
  ) u_div (
    .clk (clk),
    .rst (rst),
    .tc  (tc)
  );

  hb_irq_latch u_req (
    .clk   (clk),
    .rst   (rst),
    .set_i (tc),
    .clr_i (sw_rd),
    .irq_n (firq_n)
  );
endmodule

// File: rtl/heartbeat_irq_chk.sv
module heartbeat_irq_chk #(
  parameter int DIV_RATIO = 2048
) (
  input logic clk,
  input logic rst,
  input logic sw_rd,
  input logic tc,
  input logic firq_n
);
  int gap_q;

  always_ff @(posedge clk) begin
    if (rst || tc) begin
      gap_q <= 0;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> firq_n);

  // R6
  period_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tc |-> (gap_q == DIV_RATIO - 1));

  // R3
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!firq_n && !sw_rd) |=> !firq_n);

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_rd && !tc) |=> firq_n);

  // R7
  new_irq_wins_chk: assert property (@(posedge clk) disable iff (rst)
    tc |=> !firq_n);

  // R5
  no_spurious_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (firq_n && !tc) |=> firq_n);
endmodule

bind heartbeat_irq heartbeat_irq_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sw_rd  (sw_rd),
  .tc     (tc),
  .firq_n (firq_n)
);

// File: tb/heartbeat_irq_tb.sv
module heartbeat_irq_tb;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_rd = 1'b0;
  logic firq_n;
  logic firq_n_big;

  int n_chk = 0;
  int n_bad = 0;
  int ph = 0;

  always #4 clk = ~clk;

  heartbeat_irq #(.DIV_RATIO(D)) u_dut (
    .clk(clk), .rst(rst), .sw_rd(sw_rd), .firq_n(firq_n)
  );

  heartbeat_irq u_dut_big (
    .clk(clk), .rst(rst), .sw_rd(sw_rd), .firq_n(firq_n_big)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at phase %0d: firq_n=%b expected %b", req, ph, act, exp);
    end
  endtask

  // Advance n rising edges, landing on a falling edge.
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ph++;
    end
  endtask

  task automatic read_pulse();
    sw_rd = 1'b1;
    step(1);
    sw_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    check("R1", firq_n, 1'b1);
    check("R1", firq_n_big, 1'b1);
    rst = 1'b0;
    ph = 0;
  endtask

  task automatic t_first();
    step(D - 1);
    check("R2", firq_n, 1'b1);
    step(1);
    check("R2", firq_n, 1'b0);
  endtask

  task automatic t_hold();
    step(3 * D);
    check("R3", firq_n, 1'b0);
  endtask

  task automatic t_clear();
    step(2);
    read_pulse();
    check("R4", firq_n, 1'b1);
    step(D - 4);
    check("R5", firq_n, 1'b1);
    step(1);
    check("R6", firq_n, 1'b0);
  endtask

  task automatic t_idle_read();
    read_pulse();
    check("R4", firq_n, 1'b1);
    read_pulse();
    check("R6", firq_n, 1'b1);
    step(D - 3);
    check("R6", firq_n, 1'b1);
    step(1);
    check("R6", firq_n, 1'b0);
  endtask

  task automatic t_collide();
    step(D - 1);
    read_pulse();
    check("R7", firq_n, 1'b0);
    step(1);
    check("R7", firq_n, 1'b0);
    read_pulse();
    check("R4", firq_n, 1'b1);
  endtask

  task automatic t_reset_mid();
    step(D - 2);
    check("R8", firq_n, 1'b0);
    rst = 1'b1;
    step(1);
    check("R8", firq_n, 1'b1);
    rst = 1'b0;
    ph = 0;
    step(D - 1);
    check("R8", firq_n, 1'b1);
    step(1);
    check("R8", firq_n, 1'b0);
  endtask

  task automatic t_default_ratio();
    do_reset();
    step(2047);
    check("R2", firq_n_big, 1'b1);
    step(1);
    check("R2", firq_n_big, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_first();
    t_hold();
    t_clear();
    t_idle_read();
    t_collide();
    t_reset_mid();
    t_default_ratio();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule